// File: doc/BRIEF.md
# Gated Compare-Reset Timer

This block is a 16-bit up-counter. It advances on a synchronous tick-enable input, so there is no second clock domain. A single external gate pin can pause counting. The pin passes through a small synchronizer, and a polarity bit selects whether high or low means "count".

A compare register sits beside the counter. When the compare mode field holds the trigger code, the compare value becomes the timer period. When the count equals the compare value on an advancing tick, the count returns to zero instead of incrementing. That same event sends a one-cycle start pulse to an external converter, if the converter is enabled.

A plain rollover from all-ones to zero sets a sticky overflow flag. The compare clear never sets this flag. A bus write port loads the count, the compare value or the flag. A count write always beats a coincident compare clear.

Top module: `gated_cmp_timer`

## Requirements
- R1: With the timer on and gate mode off, every cycle with `tick` high adds 1 to `count`, whatever `gate_pin` does; a cycle with `tick` low leaves `count` unchanged.
- R2: With `tmr_on` low, `count` holds its value on every cycle that has no count write.
- R3: With `gate_en` high, an enabled tick advances the count only when the synchronized gate level equals `gate_pol`: `gate_pol`=0 counts while the pin is low, `gate_pol`=1 counts while it is high, and otherwise the count holds.
- R4: The gate pin is sampled through two flops. A pin level present before clock edge k decides whether the count advances at edge k+2.
- R5: When `cmp_mode` equals 4'b1011 and an advancing tick finds `count` equal to `cmp_val`, `count` becomes 0 instead of count+1. The count therefore runs 0 through `cmp_val` and then wraps.
- R6: A compare clear never sets `ovf_flag`, including when `cmp_val` is 16'hFFFF.
- R7: A compare clear with `adc_en` high drives `conv_start` high for exactly the one cycle after the clearing edge. With `adc_en` low, or when `cmp_mode` is not 4'b1011, `conv_start` stays low.
- R8: A count write (`wr_en`=1, `wr_sel`=2'b00) loads `wr_data` into `count` even when a compare clear or a tick happens in the same cycle. The converter pulse of a coincident match is still issued.
- R9: An advancing tick from 16'hFFFF that is not a compare clear and not overridden by a count write gives 0 and sets `ovf_flag`. The flag stays set until a flag write (`wr_sel`=2'b10) loads `wr_data[0]`. A rollover in the same cycle as a flag write wins and sets the flag. A compare write uses `wr_sel`=2'b01, and `wr_sel`=2'b11 writes nothing.
- R10: With `cmp_val`=0 in trigger mode, `count` stays at 0 and `conv_start` pulses after every advancing tick.
- R11: While `rst_n` is low and after it is released: `count`=0, `cmp_val`=0, `ovf_flag`=0 and `conv_start`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Timer clock-source enable, one cycle per count edge |
| gate_pin | input | 1 | Asynchronous gate input |
| tmr_on | input | 1 | Timer run enable |
| gate_en | input | 1 | Gate mode enable |
| gate_pol | input | 1 | Gate level that allows counting |
| cmp_mode | input | 4 | Compare mode; 4'b1011 selects reset-and-trigger |
| adc_en | input | 1 | Converter enable, gates `conv_start` |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 2 | Write target: 00 count, 01 compare, 10 flag, 11 none |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current timer count |
| cmp_val | output | 16 | Compare/period register |
| ovf_flag | output | 1 | Sticky overflow interrupt flag |
| conv_start | output | 1 | One-cycle converter start request |

## Verification
A wrong gate synchronizer or polarity check makes `count` drift from the expected value within two or three cycles of a gate edge.

A broken compare path has several visible symptoms. The count can run past the period. `conv_start` can appear in the wrong cycle. `ovf_flag` can rise at a period wrap. Each of these shows in the cycle right after the matching tick.

Wrong write priority shows in the cycle after a write coinciding with a match: the loaded value is replaced by zero. Every cycle of output is compared against an expected stream, so any such difference is caught on the cycle where it first appears.

// File: rtl/gct_pkg.sv
package gct_pkg;
   // write target decode for the bus port
   typedef enum logic [1:0] {
      SEL_COUNT = 2'b00,
      SEL_CMP   = 2'b01,
      SEL_FLAG  = 2'b10,
      SEL_NONE  = 2'b11
   } wr_sel_e;

   localparam int unsigned MODE_W      = 4;
   localparam logic [3:0]  TRIG_CODE   = 4'b1011;

   typedef struct packed {
      logic ld_count;
      logic ld_cmp;
      logic ld_flag;
   } wr_dec_t;

   function automatic wr_dec_t decode_wr(input logic en, input logic [1:0] sel);
      wr_dec_t d;
      d.ld_count = en && (sel == SEL_COUNT);
      d.ld_cmp   = en && (sel == SEL_CMP);
      d.ld_flag  = en && (sel == SEL_FLAG);
      return d;
   endfunction
endpackage

// File: rtl/gct_gate_qual.sv
module gct_gate_qual #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_pin,
   input  logic gate_en,
   input  logic gate_pol,
   output logic gate_ok
);
   logic gate_lvl;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign gate_lvl = gate_pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (SYNC_STAGES == 1) chain_q <= gate_pin;
            else chain_q <= {chain_q[SYNC_STAGES-2:0], gate_pin};
         end
         assign gate_lvl = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   // polarity match: count when synchronized level equals the selected level
   assign gate_ok = !gate_en || !(gate_lvl ^ gate_pol);
endmodule

// File: rtl/gct_cmp_unit.sv
module gct_cmp_unit #(
   parameter int unsigned WIDTH     = 16,
   parameter int unsigned MODE_W    = 4,
   parameter logic [MODE_W-1:0] TRIG_CODE = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_cmp,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic [WIDTH-1:0]  count,
   input  logic              adv,
   input  logic [MODE_W-1:0] cmp_mode,
   input  logic              adc_en,
   output logic [WIDTH-1:0]  cmp_val,
   output logic              match_clr,
   output logic              conv_start
);
   logic [WIDTH-1:0] cmp_q;
   logic             conv_q;
   logic             trig_mode;

   assign trig_mode = (cmp_mode == TRIG_CODE);
   assign match_clr = trig_mode && adv && (count == cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         conv_q <= 1'b0;
      end else begin
         if (ld_cmp) cmp_q <= wr_data;
         conv_q <= match_clr && adc_en;
      end
   end

   assign cmp_val    = cmp_q;
   assign conv_start = conv_q;
endmodule

// File: rtl/gct_count_core.sv
module gct_count_core #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             match_clr,
   input  logic             ld_count,
   input  logic             ld_flag,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] count,
   output logic             ovf_flag
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [WIDTH-1:0] cnt_q, cnt_d;
   logic             flag_q, flag_d;
   logic             rollover;

   assign rollover = adv && !match_clr && !ld_count && (cnt_q == ALL_ONES);

   always_comb begin
      cnt_d = cnt_q;
      if (ld_count)       cnt_d = wr_data;
      else if (match_clr) cnt_d = '0;
      else if (adv)       cnt_d = cnt_q + ONE;
   end

   always_comb begin
      flag_d = flag_q;
      if (rollover)     flag_d = 1'b1;
      else if (ld_flag) flag_d = wr_data[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         flag_q <= flag_d;
      end
   end

   assign count    = cnt_q;
   assign ovf_flag = flag_q;
endmodule

// File: rtl/gated_cmp_timer.sv
module gated_cmp_timer
   import gct_pkg::*;
#(
   parameter int unsigned WIDTH       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              gate_pin,
   input  logic              tmr_on,
   input  logic              gate_en,
   input  logic              gate_pol,
   input  logic [3:0]        cmp_mode,
   input  logic              adc_en,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [WIDTH-1:0]  wr_data,
   output logic [WIDTH-1:0]  count,
   output logic [WIDTH-1:0]  cmp_val,
   output logic              ovf_flag,
   output logic              conv_start
);
   initial begin
      assert (WIDTH >= 2) else $error("gated_cmp_timer: WIDTH must be at least 2");
      assert (SYNC_STAGES <= 4) else $error("gated_cmp_timer: SYNC_STAGES above 4");
   end

   wr_dec_t dec;
   logic    gate_ok;
   logic    adv;
   logic    match_clr;

   assign dec = decode_wr(wr_en, wr_sel);
   assign adv = tmr_on && tick && gate_ok;

   gct_gate_qual #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_pin (gate_pin),
      .gate_en  (gate_en),
      .gate_pol (gate_pol),
      .gate_ok  (gate_ok)
   );

   gct_cmp_unit #(.WIDTH(WIDTH), .MODE_W(MODE_W), .TRIG_CODE(TRIG_CODE)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_cmp     (dec.ld_cmp),
      .wr_data    (wr_data),
      .count      (count),
      .adv        (adv),
      .cmp_mode   (cmp_mode),
      .adc_en     (adc_en),
      .cmp_val    (cmp_val),
      .match_clr  (match_clr),
      .conv_start (conv_start)
   );

   gct_count_core #(.WIDTH(WIDTH)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .match_clr (match_clr),
      .ld_count  (dec.ld_count),
      .ld_flag   (dec.ld_flag),
      .wr_data   (wr_data),
      .count     (count),
      .ovf_flag  (ovf_flag)
   );
endmodule

// File: rtl/gct_checker.sv
module gct_checker #(
   parameter int unsigned WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             tmr_on,
   input logic [3:0]       cmp_mode,
   input logic             adc_en,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] count,
   input logic             ovf_flag,
   input logic             conv_start
);
   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   logic cnt_wr, flag_wr;
   assign cnt_wr  = wr_en && (wr_sel == 2'b00);
   assign flag_wr = wr_en && (wr_sel == 2'b10);

   // R1: no tick, no write -> hold
   assert_no_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $past(!tick && !cnt_wr) |-> count == $past(count));

   // R2: timer off holds
   assert_off_holds_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $past(!tmr_on && !cnt_wr) |-> count == $past(count));

   // R5: a trigger event leaves the count at zero unless a write intervened
   assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (conv_start && !$past(cnt_wr)) |-> count == '0);

   // R6: a clear does not touch the flag
   assert_clear_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (conv_start && !$past(flag_wr)) |-> ovf_flag == $past(ovf_flag));

   // R7: pulse only with converter enabled and trigger mode
   assert_conv_gated_R7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      conv_start |-> ($past(adc_en) && $past(cmp_mode) == 4'b1011));

   // R8: a count write always lands
   assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $past(cnt_wr) |-> count == $past(wr_data));

   // R9: the flag rises only from all-ones or a flag write
   assert_flag_rise_R9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $rose(ovf_flag) |-> ($past(count) == {WIDTH{1'b1}} || $past(flag_wr)));

   // R11: reset state
   always_comb begin
      if (!rst_n) assert_reset_state_R11: assert (count == '0 && !ovf_flag && !conv_start);
   end
endmodule

bind gated_cmp_timer gct_checker #(.WIDTH(WIDTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .tmr_on     (tmr_on),
   .cmp_mode   (cmp_mode),
   .adc_en     (adc_en),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .wr_data    (wr_data),
   .count      (count),
   .ovf_flag   (ovf_flag),
   .conv_start (conv_start)
);

// File: tb/gated_cmp_timer_tb.sv
module gated_cmp_timer_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 0, gate_pin = 0, tmr_on = 0, gate_en = 0, gate_pol = 0;
   logic [3:0]  cmp_mode = 4'h0;
   logic        adc_en = 0, wr_en = 0;
   logic [1:0]  wr_sel = 2'b11;
   logic [15:0] wr_data = 16'h0;
   logic [15:0] count, cmp_val;
   logic        ovf_flag, conv_start;

   always #(CLK_PERIOD/2) clk = ~clk;

   gated_cmp_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .gate_pin(gate_pin), .tmr_on(tmr_on),
      .gate_en(gate_en), .gate_pol(gate_pol), .cmp_mode(cmp_mode), .adc_en(adc_en),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .count(count),
      .cmp_val(cmp_val), .ovf_flag(ovf_flag), .conv_start(conv_start)
   );

   typedef struct {
      logic [15:0] cnt;
      logic [15:0] cmp;
      logic        flg;
      logic        cv;
      string       tag;
   } exp_t;

   exp_t q[$];
   int checks = 0, fails = 0;
   bit finished = 0;

   // configuration shadows, applied by the driver at its drive point
   logic s_on = 0, s_ge = 0, s_pol = 0, s_ae = 0;
   logic [3:0] s_md = 4'h0;

   // reference state, from the requirements
   logic [15:0] m_cnt = 0, m_cmp = 0;
   logic        m_flag = 0, g1 = 0, g2 = 0;

   task automatic step(input logic tk, input logic gp, input logic we,
                       input logic [1:0] ws, input logic [15:0] wd, input string tag);
      logic adv, match, wcnt, roll;
      exp_t e;
      @(negedge clk);
      tick = tk; gate_pin = gp; wr_en = we; wr_sel = ws; wr_data = wd;
      tmr_on = s_on; gate_en = s_ge; gate_pol = s_pol; adc_en = s_ae; cmp_mode = s_md;
      adv   = s_on && tk && (!s_ge || (g2 == s_pol));       // R1 R2 R3
      match = adv && (s_md == 4'b1011) && (m_cnt == m_cmp); // R5 R10
      wcnt  = we && (ws == 2'b00);                          // R8
      roll  = adv && !match && !wcnt && (m_cnt == 16'hFFFF);// R9 R6
      e.cv  = match && s_ae;                                // R7
      if (wcnt)       e.cnt = wd;
      else if (match) e.cnt = 16'h0;
      else if (adv)   e.cnt = m_cnt + 16'd1;
      else            e.cnt = m_cnt;
      if (roll)                      e.flg = 1'b1;
      else if (we && ws == 2'b10)    e.flg = wd[0];
      else                           e.flg = m_flag;
      e.cmp = (we && ws == 2'b01) ? wd : m_cmp;
      e.tag = tag;
      m_cnt = e.cnt; m_cmp = e.cmp; m_flag = e.flg;
      g2 = g1; g1 = gp;                                     // R4
      q.push_back(e);
   endtask

   task automatic run(input int n, input logic tk, input logic gp, input string tag);
      for (int i = 0; i < n; i++) step(tk, gp, 1'b0, 2'b11, 16'h0, tag);
   endtask

   // monitor: pop and compare shortly after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (count !== e.cnt || cmp_val !== e.cmp || ovf_flag !== e.flg || conv_start !== e.cv) begin
               fails++;
               $display("FAIL %s: actual cnt=%h cmp=%h flag=%b conv=%b expected cnt=%h cmp=%h flag=%b conv=%b",
                        e.tag, count, cmp_val, ovf_flag, conv_start, e.cnt, e.cmp, e.flg, e.cv);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset values while held and right after release
      checks++;
      if (count !== 0 || cmp_val !== 0 || ovf_flag !== 0 || conv_start !== 0) begin
         fails++;
         $display("FAIL R11: actual cnt=%h cmp=%h flag=%b conv=%b expected all zero",
                  count, cmp_val, ovf_flag, conv_start);
      end
      rst_n = 1'b1;
      run(1, 0, 0, "R11");

      // R1: free counting, gate ignored
      s_on = 1;
      run(3, 1, 0, "R1");
      run(2, 0, 1, "R1");
      run(3, 1, 1, "R1");
      // R2: timer off holds
      s_on = 0;
      run(4, 1, 0, "R2");
      s_on = 1;
      // R3 R4: gate polarity low, then high
      s_ge = 1; s_pol = 0;
      run(4, 1, 0, "R3");
      run(4, 1, 1, "R4");
      run(4, 1, 0, "R4");
      s_pol = 1;
      run(3, 1, 0, "R3");
      run(5, 1, 1, "R3");
      step(1, 0, 0, 2'b11, 0, "R4");
      run(3, 1, 1, "R4");
      s_ge = 0;

      // R9: rollover sets sticky flag, write clears it
      step(0, 0, 1, 2'b00, 16'hFFFE, "R8");
      run(3, 1, 0, "R9");
      run(2, 1, 0, "R9");
      step(0, 0, 1, 2'b11, 16'h1234, "R9");
      step(1, 0, 1, 2'b10, 16'h0, "R9");
      step(1, 0, 1, 2'b00, 16'hFFFF, "R9");
      step(1, 0, 1, 2'b10, 16'h0, "R9");
      step(0, 0, 1, 2'b10, 16'h0, "R9");

      // R7: no pulse outside trigger mode, even on equality
      s_md = 4'b1010; s_ae = 1;
      step(0, 0, 1, 2'b01, 16'h0003, "R7");
      step(0, 0, 1, 2'b00, 16'h0002, "R7");
      run(4, 1, 0, "R7");

      // R5 R6 R7: period 3 with converter on, then off
      s_md = 4'b1011;
      step(0, 0, 1, 2'b00, 16'h0000, "R5");
      run(10, 1, 0, "R5");
      run(2, 0, 0, "R7");
      s_ae = 0;
      run(5, 1, 0, "R7");
      s_ae = 1;
      // R6: compare at all ones wraps without flag
      step(0, 0, 1, 2'b01, 16'hFFFF, "R6");
      step(0, 0, 1, 2'b00, 16'hFFFD, "R6");
      run(4, 1, 0, "R6");

      // R8: write coinciding with a match
      step(0, 0, 1, 2'b01, 16'h0005, "R8");
      step(0, 0, 1, 2'b00, 16'h0005, "R8");
      step(1, 0, 1, 2'b00, 16'h0042, "R8");
      step(1, 0, 1, 2'b00, 16'h0005, "R8");
      step(1, 0, 0, 2'b11, 0, "R8");
      run(2, 1, 0, "R8");

      // R10: compare of zero
      step(0, 0, 1, 2'b01, 16'h0000, "R10");
      step(1, 0, 1, 2'b00, 16'h0000, "R10");
      run(5, 1, 0, "R10");
      run(2, 0, 0, "R10");
      run(3, 1, 0, "R10");

      run(2, 0, 0, "R1");
      @(negedge clk);
      @(negedge clk);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule